// File: doc/BRIEF.md
# Three-Channel Interleaved Timer Register Interface

This block is the register front end for three identical timer channels. It sits behind a simple read/write bus with a 32-bit data path. It decodes a byte offset into a register group and a channel, holds the writable configuration registers of every channel, and returns read data one cycle after the read strobe. The counting logic sits in separate channel blocks. Those blocks take their configuration from this wrapper and return their live count, event count and interrupt status to it.

Registers are interleaved by channel. Each register type occupies a 12-byte group of three consecutive words, and the word index modulo 3 picks the channel. A read of the interrupt status group raises a one-cycle clear strobe to the addressed channel, so status is returned and cleared in the same access. Each channel has its own interrupt line, which is high while any status bit is set together with its enable bit.

Read sequencing is a two-state machine. In RD_IDLE no read response is pending. RD_RESP means read data is valid on the bus in this cycle. The transitions are:
- IDLE_TO_RESP: a read is accepted in RD_IDLE.
- RESP_TO_RESP: another read is accepted while a response is being presented (back-to-back reads).
- RESP_TO_IDLE: no read is accepted while in RD_RESP.
- IDLE_HOLD: RD_IDLE is kept while no read is accepted.

A read is accepted when the read strobe is high and the write strobe is low.

Top module: `ttc_reg_wrapper`

## Requirements
- R1: The word index is byte offset >> 2. The channel is word index mod 3 and the group is word index div 3. Group codes 0..10 are: clock control, counter control, count value, interval, match 1, match 2, match 3, interrupt status, interrupt enable, event control, event count. So a group's base offset is code*12, and channels 0, 1 and 2 sit at base+0, base+4 and base+8.
- R2: Writes keep only the low bits of the write data: 6 bits for clock control, counter control and interrupt enable; 16 bits for interval and match registers; 3 bits for event control. Reads return the stored value zero-extended.
- R3: Writes to the count value, interrupt status and event count groups change no register and no channel output.
- R4: Reads of the count value and event count groups return the addressed channel's 16-bit input, zero-extended to 32 bits.
- R5: A read of the interrupt status group returns the channel's 6-bit status. In the accept cycle it raises exactly that channel's clear strobe, for one cycle per accepted read.
- R6: An offset with nonzero bits [1:0], or at or above 0x84, reads as 0, and a write to it has no effect.
- R7: A write to a match group updates only that match register of that channel.
- R8: The read data valid flag is high in exactly the cycle after each accepted read, and the read data is valid in that cycle. Back-to-back reads give back-to-back responses.
- R9: After reset, counter control is 0x21 in every channel. All other writable registers are 0, the valid flag is low and no interrupt line is high.
- R10: The interrupt line of a channel is high when its status AND its interrupt enable is nonzero, in the same cycle.
- R11: When the write and read strobes are high together, the write takes effect. The read is not accepted: no valid flag follows and no clear strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| ch_clk_ctrl | output | NUM_CH x 6 | Clock control per channel |
| ch_cnt_ctrl | output | NUM_CH x 6 | Counter control per channel |
| ch_interval | output | NUM_CH x CNT_W | Interval per channel |
| ch_match | output | NUM_CH x 3 x CNT_W | Match registers per channel |
| ch_int_en | output | NUM_CH x 6 | Interrupt enable per channel |
| ch_evt_ctrl | output | NUM_CH x 3 | Event control per channel |
| ch_count | input | NUM_CH x CNT_W | Live count from each channel |
| ch_int_stat | input | NUM_CH x 6 | Interrupt status from each channel |
| ch_evt_count | input | NUM_CH x CNT_W | Event count from each channel |
| ch_stat_clr | output | NUM_CH | Clear strobe for each channel's status |
| irq | output | NUM_CH | Interrupt line per channel |

## Verification
Results fall due at three different times:
- Register outputs change one clock edge after the write is sampled.
- Read data and its valid flag appear one edge after the read is sampled.
- The clear strobe and the interrupt lines follow the current inputs in the same cycle.

The bench drives the bus on falling edges. It advances a behavioural model at each rising edge from the values sampled there. It then compares every output 5 ns later, when the registered results of that edge have settled and the combinational outputs still reflect the inputs sampled at that edge.

// File: rtl/ttc_regs_pkg.sv
package ttc_regs_pkg;
    localparam int DATA_W    = 32;
    localparam int CLKC_W    = 6;
    localparam int CTRL_W    = 6;
    localparam int IEN_W     = 6;
    localparam int ISTAT_W   = 6;
    localparam int EVC_W     = 3;
    localparam int NUM_MATCH = 3;
    localparam int NUM_GRP   = 11;
    localparam logic [CTRL_W-1:0] CTRL_RST_VAL = 6'h21;

    typedef enum logic [3:0] {
        G_CLKC   = 4'd0,
        G_CTRL   = 4'd1,
        G_COUNT  = 4'd2,
        G_INTV   = 4'd3,
        G_MATCH0 = 4'd4,
        G_MATCH1 = 4'd5,
        G_MATCH2 = 4'd6,
        G_ISTAT  = 4'd7,
        G_IEN    = 4'd8,
        G_EVCTL  = 4'd9,
        G_EVCNT  = 4'd10
    } grp_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;
endpackage

// File: rtl/ttc_addr_decode.sv
module ttc_addr_decode
    import ttc_regs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_CH = 3,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output grp_e              grp,
    output logic [CH_W-1:0]   chan
);
    localparam int unsigned SPAN = NUM_GRP * NUM_CH;

    int unsigned word;

    // R1: interleaved layout, channel = word mod NUM_CH, group = word div NUM_CH
    always_comb begin
        word = 32'(addr[ADDR_W-1:2]);
        hit  = (addr[1:0] == 2'b00) && (word < SPAN);
        grp  = hit ? grp_e'(4'(word / NUM_CH)) : G_CLKC;
        chan = hit ? CH_W'(word % NUM_CH) : '0;
    end
endmodule

// File: rtl/ttc_chan_regs.sv
module ttc_chan_regs
    import ttc_regs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  grp_e                               grp,
    input  logic [CNT_W-1:0]                   wdata,
    output logic [CLKC_W-1:0]                  clkc,
    output logic [CTRL_W-1:0]                  ctrl,
    output logic [CNT_W-1:0]                   intv,
    output logic [NUM_MATCH-1:0][CNT_W-1:0]    match,
    output logic [IEN_W-1:0]                   ien,
    output logic [EVC_W-1:0]                   evctl
);
    // R2: each field keeps only its own width of the write data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clkc  <= '0;
            ctrl  <= CTRL_RST_VAL;
            intv  <= '0;
            ien   <= '0;
            evctl <= '0;
        end else if (we) begin
            case (grp)
                G_CLKC:  clkc  <= wdata[CLKC_W-1:0];
                G_CTRL:  ctrl  <= wdata[CTRL_W-1:0];
                G_INTV:  intv  <= wdata;
                G_IEN:   ien   <= wdata[IEN_W-1:0];
                G_EVCTL: evctl <= wdata[EVC_W-1:0];
                default: ;
            endcase
        end
    end

    // R7: one register per match group, written only by its own group code
    for (genvar m = 0; m < NUM_MATCH; m++) begin : g_match
        localparam logic [3:0] MY_G = 4'(int'(G_MATCH0) + m);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                match[m] <= '0;
            else if (we && (grp == grp_e'(MY_G)))
                match[m] <= wdata;
        end

        assert_match_isolated_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && (grp == grp_e'(MY_G))) |=> $stable(match[m]));
    end

    // R3: without a write to this channel nothing here may move
    assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable({clkc, ctrl, intv, ien, evctl}));
endmodule

// File: rtl/ttc_read_mux.sv
module ttc_read_mux
    import ttc_regs_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                                         hit,
    input  grp_e                                         grp,
    input  logic [CH_W-1:0]                              chan,
    input  logic [NUM_CH-1:0][CLKC_W-1:0]                clkc,
    input  logic [NUM_CH-1:0][CTRL_W-1:0]                ctrl,
    input  logic [NUM_CH-1:0][CNT_W-1:0]                 intv,
    input  logic [NUM_CH-1:0][NUM_MATCH-1:0][CNT_W-1:0]  match,
    input  logic [NUM_CH-1:0][IEN_W-1:0]                 ien,
    input  logic [NUM_CH-1:0][EVC_W-1:0]                 evctl,
    input  logic [NUM_CH-1:0][CNT_W-1:0]                 count,
    input  logic [NUM_CH-1:0][ISTAT_W-1:0]               istat,
    input  logic [NUM_CH-1:0][CNT_W-1:0]                 evcnt,
    output logic [DATA_W-1:0]                            rd_word
);
    // R4, R6: zero-extended fields; undefined offsets return zero
    always_comb begin
        rd_word = '0;
        if (hit) begin
            case (grp)
                G_CLKC:   rd_word = DATA_W'(clkc[chan]);
                G_CTRL:   rd_word = DATA_W'(ctrl[chan]);
                G_COUNT:  rd_word = DATA_W'(count[chan]);
                G_INTV:   rd_word = DATA_W'(intv[chan]);
                G_MATCH0: rd_word = DATA_W'(match[chan][0]);
                G_MATCH1: rd_word = DATA_W'(match[chan][1]);
                G_MATCH2: rd_word = DATA_W'(match[chan][2]);
                G_ISTAT:  rd_word = DATA_W'(istat[chan]);
                G_IEN:    rd_word = DATA_W'(ien[chan]);
                G_EVCTL:  rd_word = DATA_W'(evctl[chan]);
                G_EVCNT:  rd_word = DATA_W'(evcnt[chan]);
                default:  rd_word = '0;
            endcase
        end
    end
endmodule

// File: rtl/ttc_reg_wrapper.sv
module ttc_reg_wrapper
    import ttc_regs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         bus_wr,
    input  logic                                         bus_rd,
    input  logic [ADDR_W-1:0]                            bus_addr,
    input  logic [DATA_W-1:0]                            bus_wdata,
    output logic                                         bus_rvalid,
    output logic [DATA_W-1:0]                            bus_rdata,
    output logic [NUM_CH-1:0][CLKC_W-1:0]                ch_clk_ctrl,
    output logic [NUM_CH-1:0][CTRL_W-1:0]                ch_cnt_ctrl,
    output logic [NUM_CH-1:0][CNT_W-1:0]                 ch_interval,
    output logic [NUM_CH-1:0][NUM_MATCH-1:0][CNT_W-1:0]  ch_match,
    output logic [NUM_CH-1:0][IEN_W-1:0]                 ch_int_en,
    output logic [NUM_CH-1:0][EVC_W-1:0]                 ch_evt_ctrl,
    input  logic [NUM_CH-1:0][CNT_W-1:0]                 ch_count,
    input  logic [NUM_CH-1:0][ISTAT_W-1:0]               ch_int_stat,
    input  logic [NUM_CH-1:0][CNT_W-1:0]                 ch_evt_count,
    output logic [NUM_CH-1:0]                            ch_stat_clr,
    output logic [NUM_CH-1:0]                            irq
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic              hit;
    grp_e              grp;
    logic [CH_W-1:0]   chan;
    logic              wr_accept;
    logic              rd_accept;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rdata_q;
    rd_state_e         state_q;
    rd_state_e         state_d;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

    ttc_addr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) dec_i (
        .addr (bus_addr),
        .hit  (hit),
        .grp  (grp),
        .chan (chan)
    );

    // R11: write has priority; a read is accepted only without a write
    assign wr_accept = bus_wr && hit;
    assign rd_accept = bus_rd && !bus_wr;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        ttc_chan_regs #(.CNT_W(CNT_W)) regs_i (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_accept && (chan == CH_W'(c))),
            .grp   (grp),
            .wdata (bus_wdata[CNT_W-1:0]),
            .clkc  (ch_clk_ctrl[c]),
            .ctrl  (ch_cnt_ctrl[c]),
            .intv  (ch_interval[c]),
            .match (ch_match[c]),
            .ien   (ch_int_en[c]),
            .evctl (ch_evt_ctrl[c])
        );

        // R5: clear strobe for the addressed channel in the accept cycle
        assign ch_stat_clr[c] = rd_accept && hit && (grp == G_ISTAT) && (chan == CH_W'(c));
        // R10: per-channel interrupt line
        assign irq[c] = |(ch_int_stat[c] & ch_int_en[c]);
    end

    ttc_read_mux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) mux_i (
        .hit     (hit),
        .grp     (grp),
        .chan    (chan),
        .clkc    (ch_clk_ctrl),
        .ctrl    (ch_cnt_ctrl),
        .intv    (ch_interval),
        .match   (ch_match),
        .ien     (ch_int_en),
        .evctl   (ch_evt_ctrl),
        .count   (ch_count),
        .istat   (ch_int_stat),
        .evcnt   (ch_evt_count),
        .rd_word (rd_word)
    );

    // Read response state machine: next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: state_d = rd_accept ? RD_RESP : RD_IDLE;  // IDLE_TO_RESP / IDLE_HOLD
            RD_RESP: state_d = rd_accept ? RD_RESP : RD_IDLE;  // RESP_TO_RESP / RESP_TO_IDLE
            default: state_d = RD_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    // Output register: capture read data with each accepted read (R8)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rdata_q <= '0;
        else if (rd_accept) rdata_q <= rd_word;
    end

    assign bus_rvalid = (state_q == RD_RESP);
    assign bus_rdata  = rdata_q;

    assert_rvalid_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr) |=> bus_rvalid);

    assert_no_rvalid_without_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && !bus_wr) |=> !bus_rvalid);

    assert_clr_single_channel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_stat_clr));

    assert_clr_needs_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_stat_clr) |-> (bus_rd && !bus_wr));

    assert_oor_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && (bus_addr[1:0] != 2'b00)) |=> (bus_rdata == '0));

    assert_chan_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (32'(chan) < NUM_CH));
endmodule

// File: tb/ttc_reg_wrapper_tb.sv
module ttc_reg_wrapper_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic bus_rvalid;
    logic [31:0] bus_rdata;
    logic [2:0][5:0] o_clkc, o_ctrl, o_ien;
    logic [2:0][15:0] o_intv;
    logic [2:0][2:0][15:0] o_match;
    logic [2:0][2:0] o_evctl;
    logic [2:0][15:0] cnt_in = '0;
    logic [2:0][5:0] ist_in = '0;
    logic [2:0][15:0] evc_in = '0;
    logic [2:0] o_clr, o_irq;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;
    string cur_req = "R9";

    int unsigned m_clk[3], m_ctrl[3], m_int[3], m_ien[3], m_evc[3];
    int unsigned m_mt[3][3];
    bit e_rvalid = 0;
    int unsigned e_rdata = 0;

    always #10 clk = ~clk;

    ttc_reg_wrapper dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .ch_clk_ctrl(o_clkc), .ch_cnt_ctrl(o_ctrl), .ch_interval(o_intv),
        .ch_match(o_match), .ch_int_en(o_ien), .ch_evt_ctrl(o_evctl),
        .ch_count(cnt_in), .ch_int_stat(ist_in), .ch_evt_count(evc_in),
        .ch_stat_clr(o_clr), .irq(o_irq)
    );

    function automatic logic [11:0] ad(int g, int c);
        return 12'(g * 12 + c * 4);
    endfunction

    function automatic int unsigned model_read(int g, int c);
        case (g)
            0: return m_clk[c];
            1: return m_ctrl[c];
            2: return 32'(cnt_in[c]);
            3: return m_int[c];
            4, 5, 6: return m_mt[c][g-4];
            7: return 32'(ist_in[c]);
            8: return m_ien[c];
            9: return m_evc[c];
            10: return 32'(evc_in[c]);
            default: return 0;
        endcase
    endfunction

    task automatic chk(bit ok, string what, int unsigned act, int unsigned exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // reference model, advanced on each rising edge, compared 5 ns later
    always @(posedge clk) begin
        int w, g, c;
        bit ok;
        logic [2:0] e_clr, e_irq;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_clk[i] = 0; m_ctrl[i] = 32'h21; m_int[i] = 0; m_ien[i] = 0; m_evc[i] = 0;
                for (int j = 0; j < 3; j++) m_mt[i][j] = 0;
            end
            e_rvalid = 0;
        end else begin
            w = int'(bus_addr >> 2);
            ok = (bus_addr[1:0] == 2'b00) && (w < 33);
            g = w / 3;
            c = w % 3;
            if (bus_wr) begin
                if (ok) begin
                    case (g)
                        0: m_clk[c] = bus_wdata & 32'h3F;
                        1: m_ctrl[c] = bus_wdata & 32'h3F;
                        3: m_int[c] = bus_wdata & 32'hFFFF;
                        4, 5, 6: m_mt[c][g-4] = bus_wdata & 32'hFFFF;
                        8: m_ien[c] = bus_wdata & 32'h3F;
                        9: m_evc[c] = bus_wdata & 32'h7;
                        default: ;
                    endcase
                end
                e_rvalid = 0;
            end else if (bus_rd) begin
                e_rvalid = 1;
                e_rdata = ok ? model_read(g, c) : 0;
            end else begin
                e_rvalid = 0;
            end
        end
        #5;
        chk(bus_rvalid === e_rvalid, "R8 rvalid", 32'(bus_rvalid), 32'(e_rvalid));
        if (e_rvalid)
            chk(bus_rdata === e_rdata, "rdata", bus_rdata, e_rdata);
        for (int i = 0; i < 3; i++) begin
            chk(32'(o_clkc[i]) === m_clk[i], "clk ctrl out", 32'(o_clkc[i]), m_clk[i]);
            chk(32'(o_ctrl[i]) === m_ctrl[i], "cnt ctrl out", 32'(o_ctrl[i]), m_ctrl[i]);
            chk(32'(o_intv[i]) === m_int[i], "interval out", 32'(o_intv[i]), m_int[i]);
            chk(32'(o_ien[i]) === m_ien[i], "int enable out", 32'(o_ien[i]), m_ien[i]);
            chk(32'(o_evctl[i]) === m_evc[i], "event ctrl out", 32'(o_evctl[i]), m_evc[i]);
            for (int j = 0; j < 3; j++)
                chk(32'(o_match[i][j]) === m_mt[i][j], "match out (R7)", 32'(o_match[i][j]), m_mt[i][j]);
        end
        w = int'(bus_addr >> 2);
        ok = (bus_addr[1:0] == 2'b00) && (w < 33);
        e_clr = '0;
        if (rst_n && bus_rd && !bus_wr && ok && (w / 3 == 7)) e_clr[w % 3] = 1'b1;
        for (int i = 0; i < 3; i++) e_irq[i] = ((32'(ist_in[i]) & m_ien[i]) != 0);
        chk(o_clr === e_clr, "R5 stat clear strobe", 32'(o_clr), 32'(e_clr));
        chk(o_irq === e_irq, "R10 irq", 32'(o_irq), 32'(e_irq));
    end

    task automatic cyc(bit w, bit r, logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 12'h0, 32'h0);
    endtask

    task automatic read_all();
        for (int g = 0; g < 11; g++)
            for (int c = 0; c < 3; c++) cyc(0, 1, ad(g, c), 32'h0);
        idle(1);
    endtask

    initial begin
        // R9: reset state
        cur_req = "R9";
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        read_all();

        // R2: masking of every writable group
        cur_req = "R2";
        foreach (m_clk[c]) begin
            foreach (cnt_in[k]) ;
        end
        for (int c = 0; c < 3; c++) begin
            for (int g = 0; g < 11; g++) begin
                cyc(1, 0, ad(g, c), 32'hFFFF_FFFF);
                cyc(0, 1, ad(g, c), 32'h0);
            end
        end
        idle(1);
        for (int c = 0; c < 3; c++)
            for (int g = 0; g < 11; g++) cyc(1, 0, ad(g, c), 32'hA5A5_5A5A ^ 32'(g * 7 + c));
        read_all();

        // R1: distinct values per channel and group, interleaved addressing
        cur_req = "R1";
        for (int g = 0; g < 11; g++)
            for (int c = 0; c < 3; c++) cyc(1, 0, ad(g, c), 32'(16'h1000 * (c + 1) + g * 17));
        read_all();

        // R7: match writes hit one register only
        cur_req = "R7";
        for (int c = 0; c < 3; c++)
            for (int m = 0; m < 3; m++) begin
                cyc(1, 0, ad(4 + m, c), 32'(16'hC000 + c * 16 + m));
                idle(1);
            end
        read_all();

        // R3: writes to read-only groups
        cur_req = "R3";
        cnt_in = {16'h3333, 16'h2222, 16'h1111};
        ist_in = {6'h15, 6'h2A, 6'h3F};
        evc_in = {16'hEEEE, 16'hDDDD, 16'hCCCC};
        for (int c = 0; c < 3; c++) begin
            cyc(1, 0, ad(2, c), 32'hFFFF_FFFF);
            cyc(1, 0, ad(7, c), 32'hFFFF_FFFF);
            cyc(1, 0, ad(10, c), 32'hFFFF_FFFF);
        end
        read_all();

        // R4: live inputs zero-extended
        cur_req = "R4";
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cnt_in = {16'(k * 16'h4321), 16'hFFFF, 16'(k + 1)};
            evc_in = {16'h8000, 16'(k * 16'h0F0F), 16'hFFFF};
            bus_wr = 0; bus_rd = 1; bus_addr = ad(2, k % 3);
            cyc(0, 1, ad(10, k % 3), 32'h0);
        end
        idle(1);

        // R5: status read and clear strobe, including repeated reads
        cur_req = "R5";
        for (int c = 0; c < 3; c++) begin
            cyc(0, 1, ad(7, c), 32'h0);
            idle(1);
        end
        cyc(0, 1, ad(7, 1), 32'h0);
        cyc(0, 1, ad(7, 1), 32'h0);
        idle(2);

        // R8: back-to-back responses
        cur_req = "R8";
        for (int g = 0; g < 11; g++) cyc(0, 1, ad(g, 2), 32'h0);
        idle(1);
        cyc(0, 1, ad(3, 0), 32'h0);
        idle(1);
        cyc(0, 1, ad(1, 1), 32'h0);
        idle(2);

        // R6: undefined and unaligned offsets
        cur_req = "R6";
        foreach (ist_in[i]) ;
        cyc(1, 0, 12'h084, 32'hFFFF_FFFF);
        cyc(1, 0, 12'h025, 32'hFFFF_FFFF);
        cyc(1, 0, 12'h032, 32'hFFFF_FFFF);
        cyc(1, 0, 12'hFFC, 32'hFFFF_FFFF);
        cyc(1, 0, 12'h200, 32'hFFFF_FFFF);
        cyc(0, 1, 12'h084, 32'h0);
        cyc(0, 1, 12'h055, 32'h0);
        cyc(0, 1, 12'h05A, 32'h0);
        cyc(0, 1, 12'hFFC, 32'h0);
        cyc(0, 1, 12'h088, 32'h0);
        idle(1);
        read_all();

        // R10: interrupt lines follow status AND enable
        cur_req = "R10";
        for (int c = 0; c < 3; c++) cyc(1, 0, ad(8, c), 32'(6'h01 << (c * 2)));
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            bus_wr = 0; bus_rd = 0;
            ist_in = {6'(k), 6'(1 << (k % 6)), 6'(k * 9)};
        end
        cyc(1, 0, ad(8, 1), 32'h0);
        idle(2);

        // R11: write and read together
        cur_req = "R11";
        ist_in = {6'h3F, 6'h3F, 6'h3F};
        cyc(1, 1, ad(7, 0), 32'h0);
        cyc(1, 1, ad(8, 2), 32'h2A);
        cyc(1, 1, ad(3, 1), 32'h1_2345);
        idle(2);
        read_all();

        idle(2);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule